// File: doc/BRIEF.md
# Software-Refilled Associative Translation Buffer

This block translates virtual addresses for a processor pipeline. It has 64 entries and is fully associative. Each entry is tagged with a virtual page number and a 6-bit address-space identifier (ASID), so the contents stay in place across a context switch and need no flush. A lookup gives the hit, miss, protection and address-error flags and the physical address in the same cycle. The top three address bits pick the segment first. Two kernel segments bypass translation and map straight onto physical memory: one cached, one uncached. The user segment and the upper kernel segment go through the associative match.

The block does not walk page tables. On a miss it raises `lk_miss`, and a software handler refills an entry through a small register-style management port. The handler loads a tag staging register and a data staging register, then commits them either to the slot named by an index register or to the slot named by a free-running random counter. The random counter never selects the low wired slots, so translations placed there stay resident. The same port can read an entry back into the staging registers. Hits update the referenced bit of the entry, and permitted writes also set its dirty bit.

Top module: `soft_tlb`

## Requirements
- R1: On a hit, `lk_paddr` is the entry's 20-bit physical page number followed by `lk_vaddr[11:0]` unchanged. This holds in user and kernel mode.
- R2: A lookup in a translated segment hits only when three conditions hold: the entry's valid bit (tag-data bit 1) is set, its VPN equals `lk_vaddr[31:12]`, and its ASID equals `lk_asid`. Otherwise `lk_miss` is raised. `lk_hit` and `lk_miss` are never high together. Addresses with top bits 0xx or 11x are translated.
- R3: In kernel mode, top bits 100 and 101 give neither hit nor miss. For both, `lk_paddr` is `lk_vaddr` with bits 31:29 cleared. `lk_uncached` is high for 101 only.
- R4: A user-mode lookup (`lk_user`=1) with `lk_vaddr[31]`=1 raises `lk_addr_err`, and raises neither hit nor miss.
- R5: A write (`lk_write`=1) that hits an entry whose writable bit (data bit 0) is clear raises `lk_prot_fault`. Reads of that entry, and writes to writable entries, raise no fault.
- R6: A hit sets the entry's referenced bit (data bit 2). A permitted write hit also sets its dirty bit (data bit 3). A faulting write does not set the dirty bit.
- R7: The random register resets to WIRED (default 4) and steps by one every cycle. From ENTRIES-1 it wraps to WIRED, and it never holds a value below WIRED.
- R8: Operation code 2'b10 on `mg_op` stores the staging registers into the slot that the random register holds in that cycle.
- R9: Operation code 2'b01 writes the staging registers into the slot named by the index register. Code 2'b11 loads that slot into the staging registers, visible one cycle later. Tag layout: {VPN[19:0], ASID[5:0]}. Data layout: {PPN[19:0], dirty, referenced, valid, writable}.
- R10: Reset clears all valid bits, the index register and both staging registers.
- R11: While `lk_valid` is low, all lookup flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 6 | Current address-space identifier |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translated segment without match |
| lk_prot_fault | output | 1 | Write to a read-only page |
| lk_addr_err | output | 1 | User access to a kernel segment |
| lk_uncached | output | 1 | Physical uncached segment |
| lk_paddr | output | 32 | Physical address |
| mg_hi_we | input | 1 | Load tag staging register |
| mg_hi_wdata | input | 26 | {VPN, ASID} |
| mg_lo_we | input | 1 | Load data staging register |
| mg_lo_wdata | input | 24 | {PPN, dirty, ref, valid, writable} |
| mg_idx_we | input | 1 | Load index register |
| mg_idx_wdata | input | 6 | New index |
| mg_op | input | 2 | 00 none, 01 write at index, 10 write at random, 11 read at index |
| mg_hi | output | 26 | Tag staging register |
| mg_lo | output | 24 | Data staging register |
| mg_index | output | 6 | Index register |
| mg_rand | output | 6 | Random register |

## Verification
All lookup outputs are combinational. The bench drives each lookup at a falling edge and samples it a quarter period later, before the next rising edge. Referenced and dirty updates, staging loads and entry commits take effect at the next rising edge. The bench therefore reads them through a read-at-index operation and compares the staging registers at the falling edge after that operation's rising edge. The random register is sampled at consecutive falling edges, each one edge apart. The value a write-at-random uses is the one sampled at the falling edge where the operation is driven.

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 4,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_valid,
  input  logic [VPN_W+OFF_W-1:0]         lk_vaddr,
  input  logic [ASID_W-1:0]              lk_asid,
  input  logic                           lk_write,
  input  logic                           lk_user,
  output logic                           lk_hit,
  output logic                           lk_miss,
  output logic                           lk_prot_fault,
  output logic                           lk_addr_err,
  output logic                           lk_uncached,
  output logic [PPN_W+OFF_W-1:0]         lk_paddr,
  input  logic                           mg_hi_we,
  input  logic [VPN_W+ASID_W-1:0]        mg_hi_wdata,
  input  logic                           mg_lo_we,
  input  logic [PPN_W+3:0]               mg_lo_wdata,
  input  logic                           mg_idx_we,
  input  logic [$clog2(ENTRIES)-1:0]     mg_idx_wdata,
  input  logic [1:0]                     mg_op,
  output logic [VPN_W+ASID_W-1:0]        mg_hi,
  output logic [PPN_W+3:0]               mg_lo,
  output logic [$clog2(ENTRIES)-1:0]     mg_index,
  output logic [$clog2(ENTRIES)-1:0]     mg_rand
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(WIRED);
  localparam logic [1:0] OP_WIDX = 2'b01, OP_WRND = 2'b10, OP_RIDX = 2'b11;

  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_r, e_d, e_w;

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;
  logic               any_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
    assign match[g] = e_v[g] && (e_vpn[g] == lk_vaddr[VA_W-1:OFF_W]) && (e_asid[g] == lk_asid);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end
  assign any_match = |match;

  wire kseg   = lk_vaddr[VA_W-1];
  wire physeg = kseg & ~lk_vaddr[VA_W-2];
  wire blocked = lk_user & kseg;
  wire live   = lk_valid & ~blocked;

  assign lk_addr_err   = lk_valid & blocked;
  assign lk_hit        = live & ~physeg & any_match;
  assign lk_miss       = live & ~physeg & ~any_match;
  assign lk_prot_fault = lk_hit & lk_write & ~e_w[sel];
  assign lk_uncached   = live & physeg & lk_vaddr[VA_W-3];
  assign lk_paddr      = physeg ? PA_W'(lk_vaddr[VA_W-4:0])
                                : {e_ppn[sel], lk_vaddr[OFF_W-1:0]};

  wire              commit = (mg_op == OP_WIDX) || (mg_op == OP_WRND);
  wire [IDX_W-1:0]  slot   = (mg_op == OP_WRND) ? mg_rand : mg_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= '0;
      e_r <= '0;
      e_d <= '0;
      e_w <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (commit && slot == IDX_W'(i)) begin
          e_d[i] <= mg_lo[3];
          e_r[i] <= mg_lo[2];
          e_v[i] <= mg_lo[1];
          e_w[i] <= mg_lo[0];
        end else if (lk_hit && sel == IDX_W'(i)) begin
          e_r[i] <= 1'b1;
          if (lk_write && e_w[i]) e_d[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (commit && slot == IDX_W'(i)) begin
        e_vpn[i]  <= mg_hi[VPN_W+ASID_W-1:ASID_W];
        e_asid[i] <= mg_hi[ASID_W-1:0];
        e_ppn[i]  <= mg_lo[PPN_W+3:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mg_hi    <= '0;
      mg_lo    <= '0;
      mg_index <= '0;
      mg_rand  <= FIRST;
    end else begin
      mg_rand <= (mg_rand == LAST) ? FIRST : mg_rand + 1'b1;
      if (mg_idx_we) mg_index <= mg_idx_wdata;
      if (mg_op == OP_RIDX) begin
        mg_hi <= {e_vpn[mg_index], e_asid[mg_index]};
        mg_lo <= {e_ppn[mg_index], e_d[mg_index], e_r[mg_index], e_v[mg_index], e_w[mg_index]};
      end else begin
        if (mg_hi_we) mg_hi <= mg_hi_wdata;
        if (mg_lo_we) mg_lo <= mg_lo_wdata;
      end
    end
  end
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic [VA_W-1:0]            lk_vaddr,
  input logic                       lk_write,
  input logic                       lk_user,
  input logic                       lk_hit,
  input logic                       lk_miss,
  input logic                       lk_prot_fault,
  input logic                       lk_addr_err,
  input logic                       lk_uncached,
  input logic [PA_W-1:0]            lk_paddr,
  input logic [$clog2(ENTRIES)-1:0] mg_rand
);
  localparam int IDX_W = $clog2(ENTRIES);

  // R7
  rand_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_rand >= IDX_W'(WIRED));

  // R7
  rand_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_rand == IDX_W'(ENTRIES - 1) |=> mg_rand == IDX_W'(WIRED));

  // R7
  rand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_rand != IDX_W'(ENTRIES - 1) |=> mg_rand == $past(mg_rand) + 1'b1);

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R4
  user_kseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_user && lk_vaddr[VA_W-1] |-> lk_addr_err && !lk_hit && !lk_miss);

  // R5
  prot_needs_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_fault |-> lk_hit && lk_write);

  // R3
  phys_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10
      |-> !lk_hit && !lk_miss && lk_paddr[PA_W-1 -: 3] == 3'b000 && lk_uncached == lk_vaddr[VA_W-3]);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault || lk_addr_err || lk_uncached));
endmodule

bind soft_tlb soft_tlb_chk #(
  .ENTRIES(ENTRIES), .WIRED(WIRED), .VA_W(VPN_W + OFF_W), .PA_W(PPN_W + OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_prot_fault(lk_prot_fault), .lk_addr_err(lk_addr_err),
  .lk_uncached(lk_uncached), .lk_paddr(lk_paddr), .mg_rand(mg_rand)
);

// File: tb/soft_tlb_test.sv
module soft_tlb_test;
  localparam int WIRED = 4;

  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        lk_hit, lk_miss, lk_prot_fault, lk_addr_err, lk_uncached;
  logic [31:0] lk_paddr;
  logic        mg_hi_we = 0, mg_lo_we = 0, mg_idx_we = 0;
  logic [25:0] mg_hi_wdata = '0;
  logic [23:0] mg_lo_wdata = '0;
  logic [5:0]  mg_idx_wdata = '0;
  logic [1:0]  mg_op = '0;
  logic [25:0] mg_hi;
  logic [23:0] mg_lo;
  logic [5:0]  mg_index, mg_rand;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  soft_tlb uut (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [5:0]  asid;
    logic        wr, usr, hit, miss, pf, ae, unc, cpa;
    logic [31:0] pa;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R1 read hit, user mode
    '{32'h00400ABC, 6'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h12345ABC, 8'd1},
    // R1 write hit on writable page
    '{32'h00401FFF, 6'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0ABCDFFF, 8'd1},
    // R1 kernel mode into user segment
    '{32'h00401004, 6'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0ABCD004, 8'd1},
    // R2 same VPN, other ASID selects other entry
    '{32'h00400123, 6'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h55555123, 8'd2},
    // R2 unknown ASID
    '{32'h00400123, 6'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        8'd2},
    // R2 invalid entry
    '{32'h60000010, 6'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        8'd2},
    // R2 no VPN match
    '{32'h00402000, 6'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        8'd2},
    // R2 kernel mapped segment
    '{32'hE0001008, 6'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00042008, 8'd2},
    // R5 write to read-only page
    '{32'h00400004, 6'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h12345004, 8'd5},
    // R3 cached physical
    '{32'h80001234, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00001234, 8'd3},
    // R3 uncached physical
    '{32'hA0ABCDEF, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00ABCDEF, 8'd3},
    // R4 user to physical segment
    '{32'h80001234, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,        8'd4},
    // R4 user to kernel mapped segment
    '{32'hE0001008, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,        8'd4}
  };

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic mg_cycle(input logic [1:0] op);
    @(negedge clk);
    mg_op = op;
    @(negedge clk);
    mg_op = 2'b00;
  endtask

  task automatic stage(input logic [25:0] hi, input logic [23:0] lo, input logic [5:0] idx);
    @(negedge clk);
    mg_hi_we = 1; mg_hi_wdata = hi;
    mg_lo_we = 1; mg_lo_wdata = lo;
    mg_idx_we = 1; mg_idx_wdata = idx;
    @(negedge clk);
    mg_hi_we = 0; mg_lo_we = 0; mg_idx_we = 0;
  endtask

  task automatic put(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                     input logic [19:0] ppn, input logic [3:0] flags);
    stage({vpn, asid}, {ppn, flags}, idx);
    mg_cycle(2'b01);
  endtask

  task automatic peek(input logic [5:0] idx);
    @(negedge clk);
    mg_idx_we = 1; mg_idx_wdata = idx;
    @(negedge clk);
    mg_idx_we = 0;
    mg_cycle(2'b11);
    #1;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic wr, input logic usr);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_user = usr;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] r, prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state, R7 reset value
    chk("R10", "index", 64'(mg_index), 64'd0);
    chk("R10", "tag staging", 64'(mg_hi), 64'd0);
    chk("R10", "data staging", 64'(mg_lo), 64'd0);
    chk("R7", "random after reset", 64'(mg_rand), 64'(WIRED));
    look(32'h00400ABC, 6'd0, 1'b0, 1'b1);
    chk("R10", "miss when empty", 64'({lk_hit, lk_miss}), 64'b01);
    lk_valid = 0;

    // data flags {dirty, ref, valid, writable}
    put(6'd0, 20'h00400, 6'd5, 20'h12345, 4'b0010);
    put(6'd1, 20'h00401, 6'd5, 20'h0ABCD, 4'b0011);
    put(6'd2, 20'h00400, 6'd9, 20'h55555, 4'b0011);
    put(6'd3, 20'h60000, 6'd5, 20'h77777, 4'b0001);
    put(6'd4, 20'hE0001, 6'd5, 20'h00042, 4'b0011);

    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[k].rq);
      look(VEC[k].va, VEC[k].asid, VEC[k].wr, VEC[k].usr);
      chk(rq, $sformatf("flags v%0d", k), 64'({lk_hit, lk_miss, lk_prot_fault, lk_addr_err, lk_uncached}),
          64'({VEC[k].hit, VEC[k].miss, VEC[k].pf, VEC[k].ae, VEC[k].unc}));
      if (VEC[k].cpa) chk(rq, $sformatf("paddr v%0d", k), 64'(lk_paddr), 64'(VEC[k].pa));
    end
    @(negedge clk);
    lk_valid = 0;

    // R11 idle lookup on a hitting address
    lk_vaddr = 32'h00400004; lk_asid = 6'd5; lk_write = 1; lk_user = 1;
    #2;
    chk("R11", "idle flags", 64'({lk_hit, lk_miss, lk_prot_fault, lk_addr_err, lk_uncached}), 64'd0);

    // R6 referenced and dirty updates, R9 read-back
    peek(6'd1);
    chk("R9", "read tag e1", 64'(mg_hi), 64'({20'h00401, 6'd5}));
    chk("R6", "e1 dirty+ref", 64'(mg_lo), 64'({20'h0ABCD, 4'b1111}));
    peek(6'd0);
    chk("R6", "e0 ref, no dirty after fault", 64'(mg_lo), 64'({20'h12345, 4'b0110}));
    peek(6'd3);
    chk("R6", "e3 untouched", 64'(mg_lo), 64'({20'h77777, 4'b0001}));

    // R8 write at random slot
    stage({20'h12340, 6'd3}, {20'h0F0F0, 4'b0011}, 6'd0);
    @(negedge clk);
    mg_op = 2'b10;
    r = mg_rand;
    @(negedge clk);
    mg_op = 2'b00;
    chk("R8", "random slot in range", 64'(r >= 6'(WIRED)), 64'd1);
    peek(r);
    chk("R8", "random slot tag", 64'(mg_hi), 64'({20'h12340, 6'd3}));
    chk("R8", "random slot data", 64'(mg_lo), 64'({20'h0F0F0, 4'b0011}));
    look(32'h12340555, 6'd3, 1'b0, 1'b1);
    chk("R8", "random entry lookup", 64'({lk_hit, lk_paddr}), 64'({1'b1, 32'h0F0F0555}));
    lk_valid = 0;

    // R7 sweep across a wrap
    @(negedge clk);
    prev = mg_rand;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      chk("R7", "random step", 64'(mg_rand), 64'((prev == 6'd63) ? 6'(WIRED) : prev + 6'd1));
      prev = mg_rand;
    end

    // R10 reset invalidates entries
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    look(32'h00400ABC, 6'd5, 1'b0, 1'b1);
    chk("R10", "miss after reset", 64'({lk_hit, lk_miss}), 64'b01);
    lk_valid = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule